// File: doc/BRIEF.md
# Guest-Shifted Timebase Counter

This block keeps a free-running host time counter and a programmable guest offset. Each cycle in which the tick strobe is high, the host counter advances by one. The integrator sets the rate of that strobe. A privileged agent can overwrite either 32-bit half of the host counter, or either half of the offset, through a single-beat write port.

The read port returns one registered value per cycle. When the guest-view input is low, that value is the host count. When it is high, the value is the host count plus the offset, wrapping modulo 2^64. Because of this, a guest sees a shifted but steadily advancing time.

The block rejects writes made while the privilege input is low. It signals each rejected write with a single-cycle error pulse.

Top module: `vtb_unit`

## Requirements
- R1: After a synchronous reset, the host counter and offset are both zero, so both read views return 0, and `wr_err` is 0.
- R2: A cycle with `tick` high and no accepted write to the host counter increases the host count by one. A wrap of the lower half from all ones carries one into the upper half.
- R3: An accepted write to selector 0 replaces the lower 32 bits of the host count with `wr_data` and keeps the upper 32 bits.
- R4: An accepted write to selector 1 replaces the upper 32 bits of the host count with `wr_data` and keeps the lower 32 bits.
- R5: If an accepted write to one host half coincides with `tick`, the written half takes `wr_data` unincremented. The other half still advances as in R2. The carry is taken from the lower half's value before the write.
- R6: Accepted writes to selector 2 and selector 3 set the lower and upper 32 bits of the offset respectively. They leave the host count unchanged.
- R7: `rd_data` is registered. One cycle after a clock edge, it shows the host count (when `rd_guest` is 0) or host plus offset modulo 2^64 (when `rd_guest` is 1), as held before that edge.
- R8: A write with `priv` low changes neither the host count nor the offset. It raises `wr_err` in the next cycle only, for exactly one cycle.
- R9: With `tick` low and no write, the host count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-advance strobe |
| priv | input | 1 | Privilege qualifier for writes |
| wr_valid | input | 1 | Write request |
| wr_sel | input | 2 | Target: 0 host low, 1 host high, 2 offset low, 3 offset high |
| wr_data | input | 32 | Write value |
| rd_guest | input | 1 | 1 selects the guest view, 0 the host view |
| rd_data | output | 64 | Registered read value |
| wr_err | output | 1 | One-cycle pulse for a rejected write |

## Verification
A host-half write and a tick can land on the same clock edge. The bench provokes this in two ways. First, it writes the upper half while the lower half is mid-count. Second, it writes the lower half while that half holds all ones, so a carry is pending. The read-back is then judged against R5: the written half must hold the raw written value, and the untouched half must show the increment and carry computed from the old lower half.

// File: rtl/vtb_pkg.sv
package vtb_pkg;
  typedef enum logic [1:0] {
    SEL_HOST_LO = 2'd0,
    SEL_HOST_HI = 2'd1,
    SEL_OFF_LO  = 2'd2,
    SEL_OFF_HI  = 2'd3
  } vtb_sel_e;
endpackage

// File: rtl/vtb_host_cnt.sv
module vtb_host_cnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic [CNT_W-1:0] count
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              carry;

  // carry is judged on the lower half as held, before any write
  assign carry = tick && (&lo_q);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_lo)      lo_d = wr_data;
    else if (tick)  lo_d = lo_q + HALF_W'(1);
    if (wr_hi)      hi_d = wr_data;
    else if (carry) hi_d = hi_q + HALF_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign count = {hi_q, lo_q};
endmodule

// File: rtl/vtb_offset.sv
module vtb_offset #(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic [CNT_W-1:0]   offset
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] half_q [2];
  logic [1:0]        wr_en;

  assign wr_en = {wr_hi, wr_lo};

  for (genvar g = 0; g < 2; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)           half_q[g] <= '0;
      else if (wr_en[g]) half_q[g] <= wr_data;
    end
  end

  assign offset = {half_q[1], half_q[0]};
endmodule

// File: rtl/vtb_view.sv
module vtb_view #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             guest,
  input  logic [CNT_W-1:0] host,
  input  logic [CNT_W-1:0] offset,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] sum;

  assign sum = host + offset;  // modulo 2^CNT_W by width

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= guest ? sum : host;
  end
endmodule

// File: rtl/vtb_unit.sv
module vtb_unit #(
  parameter int CNT_W = 64,
  parameter int SEL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               priv,
  input  logic               wr_valid,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               rd_guest,
  output logic [CNT_W-1:0]   rd_data,
  output logic               wr_err
);
  import vtb_pkg::*;

  logic             wr_ok;
  logic [3:0]       hit;
  logic [CNT_W-1:0] host_q;
  logic [CNT_W-1:0] off_q;

  assign wr_ok = wr_valid && priv;

  for (genvar s = 0; s < 4; s++) begin : g_dec
    assign hit[s] = wr_ok && (wr_sel == SEL_W'(s));
  end

  vtb_host_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_lo   (hit[SEL_HOST_LO]),
    .wr_hi   (hit[SEL_HOST_HI]),
    .wr_data (wr_data),
    .count   (host_q)
  );

  vtb_offset #(.CNT_W(CNT_W)) u_off (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (hit[SEL_OFF_LO]),
    .wr_hi   (hit[SEL_OFF_HI]),
    .wr_data (wr_data),
    .offset  (off_q)
  );

  vtb_view #(.CNT_W(CNT_W)) u_view (
    .clk     (clk),
    .rst     (rst),
    .guest   (rd_guest),
    .host    (host_q),
    .offset  (off_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_valid && !priv;
  end
endmodule

// File: rtl/vtb_unit_chk.sv
module vtb_unit_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             priv,
  input logic             wr_valid,
  input logic             rd_guest,
  input logic [CNT_W-1:0] host,
  input logic [CNT_W-1:0] off,
  input logic [CNT_W-1:0] rd_data,
  input logic             wr_err
);
  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_valid) |=> host == $past(host) + CNT_W'(1));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_valid) |=> $stable(host));

  a_r8_unpriv_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !priv && !tick) |=> ($stable(host) && $stable(off)));

  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !priv) |=> wr_err);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && !priv) |=> !wr_err);

  a_r7_guest_sum: assert property (@(posedge clk) disable iff (rst)
    rd_guest |=> rd_data == $past(host) + $past(off));

  a_r7_host_view: assert property (@(posedge clk) disable iff (rst)
    !rd_guest |=> rd_data == $past(host));
endmodule

bind vtb_unit vtb_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .priv     (priv),
  .wr_valid (wr_valid),
  .rd_guest (rd_guest),
  .host     (host_q),
  .off      (off_q),
  .rd_data  (rd_data),
  .wr_err   (wr_err)
);

// File: tb/sim_vtb_unit.sv
`timescale 1ns/1ps
module sim_vtb_unit;
  logic        clk = 1'b0;
  logic        rst, tick, priv, wr_valid, rd_guest;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [63:0] rd_data;
  logic        wr_err;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vtb_unit u0 (
    .clk(clk), .rst(rst), .tick(tick), .priv(priv), .wr_valid(wr_valid),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_guest(rd_guest),
    .rd_data(rd_data), .wr_err(wr_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    tick = 0; wr_valid = 0; priv = 1; wr_sel = 0; wr_data = 0;
  endtask

  task automatic read_view(input logic guest, output logic [63:0] v);
    idle(); rd_guest = guest;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [31:0] d,
                          input logic p, input logic t);
    wr_valid = 1; wr_sel = sel; wr_data = d; priv = p; tick = t;
    @(negedge clk);
    idle();
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk);
    end
    tick = 0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    read_view(0, v); check("R1 host", v, 64'd0);
    read_view(1, v); check("R1 guest", v, 64'd0);
    check("R1 err", {63'd0, wr_err}, 64'd0);
  endtask

  task automatic t_ticks();
    logic [63:0] v;
    do_ticks(5);
    read_view(0, v); check("R2 five ticks", v, 64'd5);
  endtask

  task automatic t_hold();
    logic [63:0] v;
    repeat (3) @(negedge clk);
    read_view(0, v); check("R9 hold", v, 64'd5);
  endtask

  task automatic t_half_writes();
    logic [63:0] v;
    do_write(2'd0, 32'hFFFF_FFFE, 1, 0);
    read_view(0, v); check("R3 low write", v, 64'h0000_0000_FFFF_FFFE);
    do_ticks(3);
    read_view(0, v); check("R2 carry", v, 64'h0000_0001_0000_0001);
    do_write(2'd1, 32'h0000_0007, 1, 0);
    read_view(0, v); check("R4 high write", v, 64'h0000_0007_0000_0001);
  endtask

  task automatic t_collide();
    logic [63:0] v;
    do_write(2'd1, 32'h0000_AAAA, 1, 1);
    read_view(0, v); check("R5 high write with tick", v, 64'h0000_AAAA_0000_0002);
    do_write(2'd0, 32'hFFFF_FFFF, 1, 0);
    do_write(2'd0, 32'h0000_0010, 1, 1);
    read_view(0, v); check("R5 low write with tick carry", v, 64'h0000_AAAB_0000_0010);
  endtask

  task automatic t_offset();
    logic [63:0] v;
    do_write(2'd2, 32'h0000_0000, 1, 0);
    do_write(2'd3, 32'hFFFF_5555, 1, 0);
    read_view(0, v); check("R6 host untouched", v, 64'h0000_AAAB_0000_0010);
    read_view(1, v); check("R7 guest wrap", v, 64'h0000_0000_0000_0010);
    do_write(2'd2, 32'h0000_0100, 1, 0);
    read_view(1, v); check("R6 offset low", v, 64'h0000_0000_0000_0110);
  endtask

  task automatic t_unpriv();
    logic [63:0] v;
    wr_valid = 1; wr_sel = 2'd0; wr_data = 32'h1234; priv = 0; tick = 0;
    @(negedge clk);
    idle();
    check("R8 err raised", {63'd0, wr_err}, 64'd1);
    @(negedge clk);
    check("R8 err one cycle", {63'd0, wr_err}, 64'd0);
    read_view(0, v); check("R8 host ignored", v, 64'h0000_AAAB_0000_0010);
    do_write(2'd3, 32'h0, 0, 0);
    read_view(1, v); check("R8 offset ignored", v, 64'h0000_0000_0000_0110);
  endtask

  initial begin
    idle(); rd_guest = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ticks();
    t_hold();
    t_half_writes();
    t_collide();
    t_offset();
    t_unpriv();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule